// File: doc/BRIEF.md
# PCM Frame and Bit Timing Recovery

This block rebuilds the frame and bit timing of a PCM highway. It takes a bit clock and a frame-sync line from outside the chip and runs them through synchronizers into a faster system clock. It then finds the edges of both signals and produces the timing that the rest of a PCM interface needs:

- a one-cycle frame-start pulse,
- a one-cycle strobe at every bit boundary,
- the bit position within the frame,
- the time-slot number, with eight bits per slot,
- the number of active highway ports.

A single 8-bit control register sets how the block reads its inputs:

- Bits [7:6] hold the highway mode. Mode 0 is 4 ports at 256 to 2048 kbit/s in 256 kbit/s steps. Mode 1 is 2 ports at 512 to 4096 kbit/s in 512 kbit/s steps. Mode 2 is 1 port at 1024 to 8192 kbit/s in 1024 kbit/s steps. Mode 3 is 2 ports at 512 to 4096 kbit/s in 512 kbit/s steps.
- Bit 5 selects double clock rate, which gives one bit per two bit-clock periods.
- Bit 4 selects the bit-clock edge that samples frame sync.
- Bits [3:0] are kept in the register but do not affect timing.

The frame length in bits is a separate configuration input. The bit counter wraps at that length, and any recognised frame sync forces the counter back to zero. The system clock must run at least four times faster than the bit clock.

Top module: `pcm_frame_timer`

## Requirements
- R1: After reset the control register reads 0x00, frame_start, bit_strobe, bit_index and slot_index are 0, and port_count is 4.
- R2: A write stores all eight bits and reads back on cfg_rdata from the next cycle. Bits [3:0] are stored without affecting timing.
- R3: port_count follows the mode in bits [7:6] one cycle after the register changes: 0 gives 4, 1 gives 2, 2 gives 1, 3 gives 2.
- R4: With bit 4 at 0, frame sync is sampled on the falling bit-clock edge, and a 0-to-1 change of the sampled value gives a frame start on the next rising bit-clock edge.
- R5: With bit 4 at 1, frame sync is sampled on the rising bit-clock edge, and a 0-to-1 change of the sampled value gives a frame start on that same rising edge.
- R6: Frame sync held high across several samples gives only one frame start.
- R7: With bit 5 at 0, every rising bit-clock edge gives one bit_strobe, and bit_index moves only on a strobe.
- R8: With bit 5 at 1, a strobe comes on the rising edge of a frame start and then on every second rising edge after it.
- R9: A write of mode 2 with bit 5 set stores bit 5 as 0, so the block runs at single rate.
- R10: bit_index counts up and returns to 0 after frame_bits-1.
- R11: A frame start comes together with a bit_strobe and sets bit_index to 0, even in the middle of a frame.
- R12: slot_index always equals bit_index divided by 8.
- R13: An edge on pdc_in or pfs_in that is present at clock edge n shows on the outputs after clock edge n+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| frame_bits | input | FBW | Frame length in bits |
| pdc_in | input | 1 | External bit clock, asynchronous |
| pfs_in | input | 1 | External frame sync, asynchronous |
| frame_start | output | 1 | Internal frame-start pulse |
| bit_strobe | output | 1 | Bit-boundary pulse |
| bit_index | output | FBW | Bit position within the frame |
| slot_index | output | FBW-3 | Time-slot number |
| port_count | output | 3 | Active port count |

## Verification
An input edge is captured at clock edge n, goes through the second synchronizer stage and the edge detector, and reaches the registered outputs after edge n+2. The reference model in the bench computes the frame start, strobe and bit index from the inputs it sees at each clock edge. It keeps each result in a queue three entries deep and compares it two edges later, at the falling clock edge. This keeps every comparison aligned with the synchronizer latency and away from the active edge.

Register writes happen only while the bit clock is idle, so a mode change never falls between an edge's capture and its effect. port_count is checked two cycles after a write: one cycle for the register and one for the output flop.

// File: rtl/pft_pkg.sv
package pft_pkg;

  typedef struct packed {
    logic [1:0] hw_mode;
    logic       dbl_rate;
    logic       smp_rise;
    logic [3:0] spare;
  } ctrl_t;

  localparam logic [1:0] HW_MODE_SINGLE_PORT = 2'd2;

  function automatic logic [2:0] ports_of(input logic [1:0] m);
    case (m)
      2'd0:    ports_of = 3'd4;
      2'd2:    ports_of = 3'd1;
      default: ports_of = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/pft_sync_edge.sv
module pft_sync_edge #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl = chain_q[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise[b] = lvl[b] & ~prev_q[b];
    assign fall[b] = ~lvl[b] & prev_q[b];
  end

endmodule

// File: rtl/pft_ctrl_reg.sv
module pft_ctrl_reg
  import pft_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output ctrl_t      ctrl,
  output logic [7:0] rdata
);

  ctrl_t ctrl_q;
  ctrl_t wr_val;

  always_comb begin
    wr_val = ctrl_t'(wdata);
    if (wr_val.hw_mode == HW_MODE_SINGLE_PORT) wr_val.dbl_rate = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (we) ctrl_q <= wr_val;
  end

  assign ctrl  = ctrl_q;
  assign rdata = ctrl_q;

endmodule

// File: rtl/pft_frame_detect.sv
module pft_frame_detect (
  input  logic clk,
  input  logic rst,
  input  logic smp_rise,
  input  logic clk_rise,
  input  logic clk_fall,
  input  logic sync_lvl,
  output logic fs_now
);

  logic last_q;
  logic pend_q;

  always_comb begin
    fs_now = 1'b0;
    if (clk_rise) fs_now = smp_rise ? (sync_lvl & ~last_q) : pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (!smp_rise && clk_fall) begin
        last_q <= sync_lvl;
        if (sync_lvl && !last_q) pend_q <= 1'b1;
      end
      if (clk_rise) begin
        if (smp_rise) last_q <= sync_lvl;
        else          pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pft_bit_counter.sv
module pft_bit_counter #(
  parameter int FBW        = 11,
  parameter int SLOT_SHIFT = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clk_rise,
  input  logic                  fs_now,
  input  logic                  dbl_rate,
  input  logic [FBW-1:0]        frame_bits,
  output logic                  frame_start,
  output logic                  bit_strobe,
  output logic [FBW-1:0]        bit_index,
  output logic [FBW-SLOT_SHIFT-1:0] slot_index
);

  logic [FBW-1:0] bit_q, nxt_bit, last_bit;
  logic           phase_q;

  assign last_bit = frame_bits - 1'b1;
  assign nxt_bit  = (bit_q >= last_bit) ? '0 : bit_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q       <= '0;
      slot_index  <= '0;
      phase_q     <= 1'b0;
      frame_start <= 1'b0;
      bit_strobe  <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      bit_strobe  <= 1'b0;
      if (clk_rise) begin
        if (fs_now) begin
          bit_q       <= '0;
          slot_index  <= '0;
          phase_q     <= 1'b0;
          frame_start <= 1'b1;
          bit_strobe  <= 1'b1;
        end else if (!dbl_rate || phase_q) begin
          bit_q       <= nxt_bit;
          slot_index  <= nxt_bit[FBW-1:SLOT_SHIFT];
          phase_q     <= 1'b0;
          bit_strobe  <= 1'b1;
        end else begin
          phase_q <= 1'b1;
        end
      end
    end
  end

  assign bit_index = bit_q;

endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pft_pkg::*;
#(
  parameter int FBW       = 11,
  parameter int SYNC_STG  = 2,
  parameter int SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic [FBW-1:0]       frame_bits,
  input  logic                 pdc_in,
  input  logic                 pfs_in,
  output logic                 frame_start,
  output logic                 bit_strobe,
  output logic [FBW-1:0]       bit_index,
  output logic [FBW-$clog2(SLOT_BITS)-1:0] slot_index,
  output logic [2:0]           port_count
);

  localparam int SLOT_SHIFT = $clog2(SLOT_BITS);

  ctrl_t      ctrl;
  logic [1:0] s_lvl, s_rise, s_fall;
  logic       fs_now;

  pft_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .ctrl(ctrl), .rdata(cfg_rdata)
  );

  pft_sync_edge #(.STAGES(SYNC_STG), .W(2)) u_sync (
    .clk(clk), .rst(rst), .async_in({pfs_in, pdc_in}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  pft_frame_detect u_fdet (
    .clk(clk), .rst(rst), .smp_rise(ctrl.smp_rise),
    .clk_rise(s_rise[0]), .clk_fall(s_fall[0]),
    .sync_lvl(s_lvl[1]), .fs_now(fs_now)
  );

  pft_bit_counter #(.FBW(FBW), .SLOT_SHIFT(SLOT_SHIFT)) u_cnt (
    .clk(clk), .rst(rst), .clk_rise(s_rise[0]), .fs_now(fs_now),
    .dbl_rate(ctrl.dbl_rate), .frame_bits(frame_bits),
    .frame_start(frame_start), .bit_strobe(bit_strobe),
    .bit_index(bit_index), .slot_index(slot_index)
  );

  always_ff @(posedge clk) begin
    if (rst) port_count <= 3'd4;
    else     port_count <= ports_of(ctrl.hw_mode);
  end

endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
  parameter int FBW = 11,
  parameter int SW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [7:0]     cfg_rdata,
  input logic           frame_start,
  input logic           bit_strobe,
  input logic [FBW-1:0] bit_index,
  input logic [SW-1:0]  slot_index,
  input logic [2:0]     port_count
);

  assert_index_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !bit_strobe |-> $stable(bit_index));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |=> !bit_strobe);

  assert_fs_zero_R11: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (bit_strobe && bit_index == '0));

  assert_mode2_single_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[7:6] == 2'd2) |-> !cfg_rdata[5]);

  assert_ports_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(port_count) == 1);

  assert_slot_div_R12: assert property (@(posedge clk) disable iff (rst)
    slot_index == SW'(bit_index >> (FBW - SW)));

endmodule

bind pcm_frame_timer pft_checker #(.FBW(FBW), .SW(FBW - $clog2(SLOT_BITS))) u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
  .bit_strobe(bit_strobe), .bit_index(bit_index), .slot_index(slot_index),
  .port_count(port_count)
);

// File: tb/tb_pcm_frame_timer.sv
module tb_pcm_frame_timer;
  localparam int FBW = 11;

  logic clk = 0, rst = 1, cfg_we = 0, pdc_in = 0, pfs_in = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [FBW-1:0] frame_bits;
  logic frame_start, bit_strobe;
  logic [FBW-1:0] bit_index;
  logic [FBW-4:0] slot_index;
  logic [2:0] port_count;

  int total = 0, bad = 0, fb = 32, fs_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign frame_bits = fb[FBW-1:0];

  pcm_frame_timer dut (.*);

  typedef struct { bit fs; bit st; int bi; } exp_t;
  exp_t q[$];
  bit pp, lastf, pend, ph, sm, dbl;

  // behavioural reference: events from the inputs seen at each posedge
  always @(posedge clk) begin
    if (rst) begin
      q.delete(); pp = 0; lastf = 0; pend = 0; ph = 0; sm = 0; dbl = 0;
    end else begin
      exp_t e;
      bit rs, fl;
      e = q.size() ? q[q.size()-1] : '{0, 0, 0};
      e.fs = 0; e.st = 0;
      if (cfg_we) begin
        sm  = cfg_wdata[4];
        dbl = cfg_wdata[5] && (cfg_wdata[7:6] != 2);
      end
      rs = pdc_in & ~pp; fl = ~pdc_in & pp; pp = pdc_in;
      if (fl && !sm) begin if (pfs_in && !lastf) pend = 1; lastf = pfs_in; end
      if (rs && sm) begin if (pfs_in && !lastf) e.fs = 1; lastf = pfs_in; end
      else if (rs && pend) begin e.fs = 1; pend = 0; end
      if (rs) begin
        if (e.fs) begin e.bi = 0; ph = 0; e.st = 1; end
        else if (!dbl || ph) begin e.bi = (e.bi >= fb-1) ? 0 : e.bi+1; ph = 0; e.st = 1; end
        else ph = 1;
      end
      q.push_back(e);
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, two edges after the inputs were captured (R13)
  always @(negedge clk) begin
    if (!rst && q.size() == 3) begin
      exp_t e;
      e = q.pop_front();
      chk("R4/R5/R6 frame_start", frame_start, e.fs);
      chk("R7/R8 bit_strobe", bit_strobe, e.st);
      chk("R10/R11 bit_index", bit_index, e.bi);
      chk("R12 slot_index", slot_index, e.bi / 8);
      if (frame_start) fs_seen++;
    end
  end

  task automatic pdc_period(int h, logic f);
    pfs_in = f; pdc_in = 1;
    repeat (h) @(negedge clk);
    pdc_in = 0;
    repeat (h) @(negedge clk);
  endtask

  task automatic run(int n, int h, int pulse_at);
    for (int i = 0; i < n; i++) pdc_period(h, i == pulse_at);
    pfs_in = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    cfg_wdata = v; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 cfg_rdata", cfg_rdata, 0);
    chk("R1 frame_start", frame_start, 0);
    chk("R1 bit_strobe", bit_strobe, 0);
    chk("R1 bit_index", bit_index, 0);
    chk("R1 port_count", port_count, 4);
    rst = 0;
    repeat (4) @(negedge clk);

    // R4 R7 R10 R11: falling-edge sampling, single rate, wrap, mid-frame resync
    run(45, 4, 2);
    run(30, 4, 10);
    // R4 R6: sync held high over several samples
    fs_seen = 0;
    for (int i = 0; i < 5; i++) pdc_period(4, 1);
    run(4, 4, -1);
    chk("R6 single frame start", fs_seen, 1);

    // R5 R2: rising-edge sampling, spare bits stored
    wr(8'h1A);
    chk("R2 readback", cfg_rdata, 8'h1A);
    chk("R3 mode0 ports", port_count, 4);
    run(40, 4, 3);
    run(20, 2, 7);

    // R8: double rate, both sampling edges
    wr(8'h20);
    run(50, 4, 1);
    wr(8'h70);
    chk("R3 mode1 ports", port_count, 2);
    fb = 24;
    run(60, 2, 4);

    // R9: mode 2 forces single rate
    wr(8'hA0);
    chk("R9 rdata forced", cfg_rdata, 8'h80);
    chk("R3 mode2 ports", port_count, 1);
    run(30, 4, 2);
    wr(8'hBF);
    chk("R9 rdata forced sm", cfg_rdata, 8'h9F);
    run(30, 3, 5);
    wr(8'hC5);
    chk("R3 mode3 ports", port_count, 2);
    chk("R2 readback mode3", cfg_rdata, 8'hC5);

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule